// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Controller

This block turns one PWM level into two gate-drive enables for a synchronous half-bridge: a high-side enable that follows PWM high and a low-side enable that follows PWM low. The two enables never overlap. The block does not switch on a fixed delay from the PWM edge. On each transition it first removes the active enable. It then waits until digital monitor flags show that the outgoing switch has stopped conducting. After that it counts a programmable turn-on delay before it enables the incoming switch. If the monitor never confirms, a timeout lets the sequence go on as if it had. A minimum off time keeps the low-side enable low for a set number of cycles each time it is removed.

An enable input (low means disable), a supply-undervoltage flag and an overtemperature flag each force both enables low. Once every forcing condition has cleared, the block resumes only by running the normal break-before-make sequence for the current PWM level.

All inputs are plain level signals from the analog front end. They pass through a synchronizer of `SYNC_STAGES` flops before any logic uses them. Both enables are registered. The delays, the timeout and the minimum off time are parameters counted in clock cycles. In the latency figures below, S = `SYNC_STAGES` + 1 (3 with the defaults).

Top module: `dtc_gate_ctrl`

## Requirements
- R1: During reset both enables are low. After reset release, with PWM low, the drive enabled and no fault, the low-side enable rises S+1+`LS_ON_DLY` cycles after release.
- R2: When PWM goes high from the low-side-on state, the low-side enable falls S cycles later. With a monitor that follows the gate at once, the high-side enable rises 2*S+`HS_ON_DLY` cycles after the PWM edge.
- R3: When PWM goes low from the high-side-on state, the high-side enable falls S cycles later. The low-side enable rises 2*S+`LS_ON_DLY` cycles after the edge, and only once both the high-side gate monitor and the switch-node-high flag have been seen low.
- R4: If the monitor stays asserted, the pending enable still rises after `MON_TIMEOUT` cycles of waiting plus its turn-on delay. That is S+`MON_TIMEOUT`+`HS_ON_DLY` cycles after a rising PWM edge and S+`MON_TIMEOUT`+`LS_ON_DLY` cycles after a falling one.
- R5: A low level on `drv_enable_i` forces both enables low S cycles later.
- R6: A high level on `uvlo_i` forces both enables low S cycles later.
- R7: A high level on `thermal_trip_i` forces both enables low S cycles later. While any forcing condition holds, PWM changes have no effect on either enable.
- R8: After the last forcing condition clears, the block re-runs the break-before-make sequence. With PWM high, the high-side enable rises S+1+`HS_ON_DLY` cycles after the release. With PWM low, the low-side enable rises S+1+`LS_ON_DLY` cycles after the release.
- R9: Once the low-side enable falls, for any reason, it stays low for more than `LS_MIN_OFF` cycles. A short PWM high pulse therefore delays its return to S+`LS_MIN_OFF`+1 cycles after the pulse starts.
- R10: The high-side and low-side enables are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command: high selects the high side, low selects the low side |
| drv_enable_i | input | 1 | Drive enable; low forces both enables off |
| uvlo_i | input | 1 | Supply undervoltage flag, active high |
| thermal_trip_i | input | 1 | Overtemperature flag, active high |
| hs_gate_mon_i | input | 1 | High-side gate still on |
| ls_gate_mon_i | input | 1 | Low-side gate still on |
| sw_node_hi_i | input | 1 | Switch node still high |
| hs_drv_o | output | 1 | High-side gate-drive enable |
| ls_drv_o | output | 1 | Low-side gate-drive enable |

## Verification
Each input is seen by the sequencer S cycles after it is driven. Removal of an enable and any forced-off state therefore appear S cycles after the stimulus. The incoming enable appears S more cycles later, once the monitor echo has crossed the synchronizer, plus its turn-on delay. The timeout, restart and minimum-off paths have the fixed offsets given in R4, R8 and R9. The bench drives inputs on falling clock edges and counts falling edges to the exact cycle each formula gives. It checks the value one cycle before the change as well as the cycle of the change, so a result that is early or late by one cycle fails. During random stimulus it checks every cycle against fault levels it drove S cycles earlier.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [2:0] {
    ST_SAFE      = 3'd0,
    ST_WAIT_LS   = 3'd1,
    ST_HS_DLY    = 3'd2,
    ST_HS_ON     = 3'd3,
    ST_WAIT_HS   = 3'd4,
    ST_LS_DLY    = 3'd5,
    ST_LS_ON     = 3'd6
  } dtc_state_e;
endpackage

// File: rtl/dtc_sync.sv
module dtc_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dtc_minoff.sv
module dtc_minoff #(
  parameter int MIN_OFF = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ls_off_evt,
  output logic ls_allow
);
  localparam int CW = $clog2(MIN_OFF + 1);
  localparam logic [CW-1:0] LOAD = CW'(MIN_OFF);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (ls_off_evt)     remain <= LOAD;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign ls_allow = (remain == '0);
endmodule

// File: rtl/dtc_seq.sv
module dtc_seq
  import dtc_pkg::*;
#(
  parameter int HS_ON_DLY   = 3,
  parameter int LS_ON_DLY   = 5,
  parameter int MON_TIMEOUT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm,
  input  logic fault,
  input  logic hs_mon,
  input  logic ls_mon,
  input  logic sw_hi,
  input  logic ls_allow,
  output logic hs_drv,
  output logic ls_drv,
  output logic ls_off_evt
);
  localparam int MAX_A = (HS_ON_DLY > LS_ON_DLY) ? HS_ON_DLY : LS_ON_DLY;
  localparam int MAX_V = (MAX_A > MON_TIMEOUT) ? MAX_A : MON_TIMEOUT;
  localparam int CW    = $clog2(MAX_V + 1);
  localparam logic [CW-1:0] HS_LAST = CW'(HS_ON_DLY - 1);
  localparam logic [CW-1:0] LS_LAST = CW'(LS_ON_DLY - 1);
  localparam logic [CW-1:0] TO_LAST = CW'(MON_TIMEOUT - 1);

  dtc_state_e    st, nxt;
  logic [CW-1:0] cnt;
  logic          clr;

  always_comb begin
    nxt = st;
    clr = 1'b0;
    unique case (st)
      ST_SAFE: begin
        nxt = pwm ? ST_WAIT_LS : ST_WAIT_HS;
        clr = 1'b1;
      end
      ST_WAIT_LS: begin
        if (!pwm) begin
          nxt = ST_WAIT_HS; clr = 1'b1;
        end else if (!ls_mon || cnt == TO_LAST) begin
          nxt = ST_HS_DLY;  clr = 1'b1;
        end
      end
      ST_HS_DLY: begin
        if (!pwm) begin
          nxt = ST_WAIT_HS; clr = 1'b1;
        end else if (cnt == HS_LAST) begin
          nxt = ST_HS_ON;   clr = 1'b1;
        end
      end
      ST_HS_ON: begin
        if (!pwm) begin
          nxt = ST_WAIT_HS; clr = 1'b1;
        end
      end
      ST_WAIT_HS: begin
        if (pwm) begin
          nxt = ST_WAIT_LS; clr = 1'b1;
        end else if ((!hs_mon && !sw_hi) || cnt == TO_LAST) begin
          nxt = ST_LS_DLY;  clr = 1'b1;
        end
      end
      ST_LS_DLY: begin
        if (pwm) begin
          nxt = ST_WAIT_LS; clr = 1'b1;
        end else if (cnt >= LS_LAST && ls_allow) begin
          nxt = ST_LS_ON;   clr = 1'b1;
        end
      end
      ST_LS_ON: begin
        if (pwm) begin
          nxt = ST_WAIT_LS; clr = 1'b1;
        end
      end
      default: begin
        nxt = ST_SAFE; clr = 1'b1;
      end
    endcase
    if (fault) begin
      nxt = ST_SAFE;
      clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_SAFE;
      cnt    <= '0;
      hs_drv <= 1'b0;
      ls_drv <= 1'b0;
    end else begin
      st     <= nxt;
      hs_drv <= (nxt == ST_HS_ON);
      ls_drv <= (nxt == ST_LS_ON);
      if (clr)              cnt <= '0;
      else if (cnt != '1)   cnt <= cnt + 1'b1;
    end
  end

  assign ls_off_evt = ls_drv && (nxt != ST_LS_ON);
endmodule

// File: rtl/dtc_gate_ctrl.sv
module dtc_gate_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int HS_ON_DLY   = 3,
  parameter int LS_ON_DLY   = 5,
  parameter int MON_TIMEOUT = 12,
  parameter int LS_MIN_OFF  = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic drv_enable_i,
  input  logic uvlo_i,
  input  logic thermal_trip_i,
  input  logic hs_gate_mon_i,
  input  logic ls_gate_mon_i,
  input  logic sw_node_hi_i,
  output logic hs_drv_o,
  output logic ls_drv_o
);
  localparam int NIN = 7;
  // reset values: PWM low, drive disabled, faults and monitors asserted
  localparam logic [NIN-1:0] SYNC_RST = 7'b1111100;

  logic [NIN-1:0] raw, syn;
  logic pwm_s, en_s, uvlo_s, therm_s, hs_mon_s, ls_mon_s, sw_s;
  logic fault_s, ls_allow, ls_off_evt;

  assign raw = {sw_node_hi_i, ls_gate_mon_i, hs_gate_mon_i,
                thermal_trip_i, uvlo_i, drv_enable_i, pwm_i};

  dtc_sync #(.WIDTH(NIN), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  assign {sw_s, ls_mon_s, hs_mon_s, therm_s, uvlo_s, en_s, pwm_s} = syn;
  assign fault_s = !en_s || uvlo_s || therm_s;

  dtc_seq #(.HS_ON_DLY(HS_ON_DLY), .LS_ON_DLY(LS_ON_DLY),
            .MON_TIMEOUT(MON_TIMEOUT)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwm(pwm_s), .fault(fault_s),
    .hs_mon(hs_mon_s), .ls_mon(ls_mon_s), .sw_hi(sw_s),
    .ls_allow(ls_allow), .hs_drv(hs_drv_o), .ls_drv(ls_drv_o),
    .ls_off_evt(ls_off_evt)
  );

  dtc_minoff #(.MIN_OFF(LS_MIN_OFF)) u_minoff (
    .clk(clk), .rst_n(rst_n), .ls_off_evt(ls_off_evt), .ls_allow(ls_allow)
  );
endmodule

// File: rtl/dtc_gate_chk.sv
module dtc_gate_chk #(
  parameter int MIN_OFF = 20
) (
  input logic clk,
  input logic rst_n,
  input logic hs,
  input logic ls,
  input logic en_s,
  input logic uvlo_s,
  input logic therm_s
);
  localparam int CW = $clog2(MIN_OFF + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_OFF);

  logic [CW-1:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             low_run <= SAT;
    else if (ls)            low_run <= '0;
    else if (low_run != SAT) low_run <= low_run + 1'b1;
  end

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs && ls));

  p_disable_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!hs && !ls));

  p_uvlo_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_s |=> (!hs && !ls));

  p_thermal_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    therm_s |=> (!hs && !ls));

  p_hs_after_ls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs) |-> !$past(ls));

  p_ls_after_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls) |-> !$past(hs));

  p_ls_min_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls) |-> (low_run >= SAT));
endmodule

bind dtc_gate_ctrl dtc_gate_chk #(.MIN_OFF(LS_MIN_OFF)) u_chk (
  .clk(clk), .rst_n(rst_n), .hs(hs_drv_o), .ls(ls_drv_o),
  .en_s(en_s), .uvlo_s(uvlo_s), .therm_s(therm_s)
);

// File: tb/dtc_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module dtc_gate_ctrl_tb_top;
  localparam int STG = 2;
  localparam int HSD = 3;
  localparam int LSD = 5;
  localparam int TMO = 12;
  localparam int MOF = 20;
  localparam int SL  = STG + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0, en = 1'b1, uvlo = 1'b0, therm = 1'b0;
  logic stuck_hs = 1'b0, stuck_ls = 1'b0, stuck_sw = 1'b0;
  logic hs, ls;
  logic hs_mon, ls_mon, sw_mon;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // monitor echo: gates follow the enables at once unless held stuck
  assign hs_mon = hs | stuck_hs;
  assign ls_mon = ls | stuck_ls;
  assign sw_mon = hs | stuck_sw;

  dtc_gate_ctrl #(.SYNC_STAGES(STG), .HS_ON_DLY(HSD), .LS_ON_DLY(LSD),
                  .MON_TIMEOUT(TMO), .LS_MIN_OFF(MOF)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .drv_enable_i(en),
    .uvlo_i(uvlo), .thermal_trip_i(therm), .hs_gate_mon_i(hs_mon),
    .ls_gate_mon_i(ls_mon), .sw_node_hi_i(sw_mon),
    .hs_drv_o(hs), .ls_drv_o(ls)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  function automatic logic forced(input logic [2:0] f);
    return |f;
  endfunction

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [2:0] hist [SL];
    int low_run;
    logic ls_prev;
    void'($urandom(32'd20240611));

    // R1: reset state and first sequence
    tick(3);
    chk("R1 hs low in reset", hs, 1'b0);
    chk("R1 ls low in reset", ls, 1'b0);
    rst_n = 1'b1;
    tick(SL + LSD);
    chk("R1 ls not yet on", ls, 1'b0);
    tick(1);
    chk("R1 ls on after start sequence", ls, 1'b1);
    tick(30);

    // R2: rising PWM
    pwm = 1'b1;
    tick(SL - 1);
    chk("R2 ls still on", ls, 1'b1);
    tick(1);
    chk("R2 ls removed", ls, 1'b0);
    tick(SL + HSD - 1);
    chk("R2 hs not yet on", hs, 1'b0);
    tick(1);
    chk("R2 hs on after dead time", hs, 1'b1);
    tick(30);

    // R3: falling PWM
    pwm = 1'b0;
    tick(SL - 1);
    chk("R3 hs still on", hs, 1'b1);
    tick(1);
    chk("R3 hs removed", hs, 1'b0);
    tick(SL + LSD - 1);
    chk("R3 ls not yet on", ls, 1'b0);
    tick(1);
    chk("R3 ls on after dead time", ls, 1'b1);
    tick(30);

    // R4: timeout on rising edge, low-side monitor stuck on
    stuck_ls = 1'b1;
    pwm = 1'b1;
    tick(SL);
    chk("R4 ls removed", ls, 1'b0);
    tick(TMO + HSD - 1);
    chk("R4 hs waits for timeout", hs, 1'b0);
    tick(1);
    chk("R4 hs on after timeout", hs, 1'b1);
    stuck_ls = 1'b0;
    tick(30);

    // R4: timeout on falling edge, switch node stuck high
    stuck_sw = 1'b1;
    pwm = 1'b0;
    tick(SL + TMO + LSD - 1);
    chk("R4 ls waits for timeout", ls, 1'b0);
    tick(1);
    chk("R4 ls on after timeout", ls, 1'b1);
    stuck_sw = 1'b0;
    tick(30);

    // R9: short PWM pulse, minimum low-side off time
    pwm = 1'b1;
    tick(2);
    pwm = 1'b0;
    tick(SL + MOF - 2);
    chk("R9 ls held off", ls, 1'b0);
    chk("R9 hs stays off for short pulse", hs, 1'b0);
    tick(1);
    chk("R9 ls returns after min off", ls, 1'b1);
    tick(30);

    // R5 and R8: disable during high-side on, then restart
    pwm = 1'b1;
    tick(30);
    chk("R2 hs on before disable", hs, 1'b1);
    en = 1'b0;
    tick(SL - 1);
    chk("R5 hs before disable lands", hs, 1'b1);
    tick(1);
    chk("R5 hs forced off", hs, 1'b0);
    tick(5);
    en = 1'b1;
    tick(SL + HSD);
    chk("R8 hs not yet back", hs, 1'b0);
    tick(1);
    chk("R8 hs back after sequence", hs, 1'b1);
    tick(30);

    // R6 and R8: undervoltage during low-side on
    pwm = 1'b0;
    tick(30);
    chk("R3 ls on before uvlo", ls, 1'b1);
    uvlo = 1'b1;
    tick(SL - 1);
    chk("R6 ls before uvlo lands", ls, 1'b1);
    tick(1);
    chk("R6 ls forced off", ls, 1'b0);
    tick(30);
    uvlo = 1'b0;
    tick(SL + LSD);
    chk("R8 ls not yet back", ls, 1'b0);
    tick(1);
    chk("R8 ls back after sequence", ls, 1'b1);
    tick(30);

    // R7: thermal trip, PWM ignored while held
    therm = 1'b1;
    tick(SL);
    chk("R7 ls forced off", ls, 1'b0);
    pwm = 1'b1;
    for (int i = 0; i < 12; i++) begin
      tick(1);
      chk("R7 hs ignores PWM", hs, 1'b0);
      chk("R7 ls ignores PWM", ls, 1'b0);
    end
    therm = 1'b0;
    tick(30);
    chk("R8 hs on after thermal clears", hs, 1'b1);

    // random phase: R10 overlap, R5 R6 R7 forced-low, R9 min off
    for (int k = 0; k < SL; k++) hist[k] = 3'b000;
    low_run = 1000;
    ls_prev = ls;
    for (int i = 0; i < 4000; i++) begin
      chk("R10 no overlap", hs & ls, 1'b0);
      if (forced(hist[SL-1])) begin
        if (hist[SL-1][0])      chk("R5 random disable", hs | ls, 1'b0);
        else if (hist[SL-1][1]) chk("R6 random uvlo", hs | ls, 1'b0);
        else                    chk("R7 random thermal", hs | ls, 1'b0);
      end
      if (ls && !ls_prev) chk("R9 random min off", logic'(low_run >= MOF), 1'b1);
      if (ls) low_run = 0;
      else    low_run++;
      ls_prev = ls;

      if (($urandom % 20) == 0) pwm = ~pwm;
      en    = (($urandom % 50) != 0);
      uvlo  = (($urandom % 60) == 0);
      therm = (($urandom % 70) == 0);
      for (int k = SL - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = {therm, uvlo, ~en};
      tick(1);
    end

    done = 1'b1;
    report();
    $finish;
  end
endmodule